// File: doc/BRIEF.md
# UART Interrupt and FIFO-Level Controller

This block turns the activity of a UART into interrupt status. It watches the fill counts of the receive and transmit FIFOs, single-cycle pulses for receive-side character errors, a pulse for a change on the clear-to-send line and a tick that marks each bit period. From these it keeps a raw status word, a mask word written by software, the masked status and one combined interrupt line. It also gates the receive DMA request when errors are pending.

FIFO trigger points are chosen separately for receive and transmit as fractions of the FIFO depth. A receive-timeout detector raises status when characters sit unread in the receive FIFO for a set number of bit periods. Software clears status bits by writing ones. The FIFOs, the shift registers and the bus decoder that produces the write strobes live outside this block.

Status word bit positions: overrun 10, break 9, parity 8, framing 7, receive timeout 6, transmit level 5, receive level 4, clear-to-send change 1. The other bits always read 0.

Top module: `uart_irq_ctrl`

## Requirements
- R1: In FIFO mode (`cfg_fifo_en`=1, depth 32) the 3-bit level code gives the threshold: 0→4, 1→8, 2→16, 3→24, 4→28 entries. The reserved codes 5, 6 and 7 act as code 4.
- R2: Receive-level status (bit 4) sets on the clock edge after `rx_fill` first reaches or passes the receive threshold. Transmit-level status (bit 5) sets on the edge after `tx_fill` first drops to or below the transmit threshold. Each clears on the edge after its condition stops holding, and does not set again until the condition has lapsed and returned.
- R3: With `cfg_fifo_en`=0 the receive condition is `rx_fill`≠0 and the transmit condition is `tx_fill`=0.
- R4: With mask bit 6 set and `rx_fill`≠0, timeout status (bit 6) sets on the edge that ends the 32nd `bit_tick` cycle since the last `rx_push` or since the FIFO became non-empty. It clears when `rx_fill` is 0 or when clear bit 6 is written.
- R5: Timeout status never sets while mask bit 6 is 0.
- R6: An error or CTS event pulse sets its status bit on the next edge. The bit holds until it is cleared. A set and a clear in the same cycle leave the bit at 1.
- R7: `clr_wr` with a 1 in a bit position clears that status bit. Zero bits in `clr_wdata` leave status unchanged.
- R8: `mask_wr` loads `mask_wdata`, keeping only bits 10:4 and 1. `masked_stat` equals `raw_stat` AND `mask_q`.
- R9: `irq` is the OR of all `masked_stat` bits.
- R10: When `cfg_dma_err_block`=1 and any of status bits 10:7 is set, `rx_dma_req` is 0. Otherwise it follows `rx_dma_req_in`.
- R11: While `rst` is high, `raw_stat`, `mask_q` and `irq` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fifo_en | input | 1 | 1: FIFO mode, 0: single-slot mode |
| cfg_rx_lvl | input | 3 | Receive trigger level code |
| cfg_tx_lvl | input | 3 | Transmit trigger level code |
| cfg_dma_err_block | input | 1 | Block receive DMA while errors are pending |
| rx_fill | input | 6 | Receive FIFO occupancy |
| tx_fill | input | 6 | Transmit FIFO occupancy |
| rx_push | input | 1 | A character entered the receive FIFO |
| bit_tick | input | 1 | One pulse per bit period |
| ev_overrun | input | 1 | Overrun event pulse |
| ev_break | input | 1 | Break event pulse |
| ev_parity | input | 1 | Parity error event pulse |
| ev_framing | input | 1 | Framing error event pulse |
| ev_cts | input | 1 | Clear-to-send change event pulse |
| mask_wr | input | 1 | Mask write strobe |
| mask_wdata | input | 11 | Mask write data |
| clr_wr | input | 1 | Clear write strobe |
| clr_wdata | input | 11 | Clear write data, 1 clears |
| rx_dma_req_in | input | 1 | Receive DMA request from the FIFO side |
| raw_stat | output | 11 | Raw status word |
| mask_q | output | 11 | Current mask word |
| masked_stat | output | 11 | Masked status word |
| irq | output | 1 | Combined interrupt |
| rx_dma_req | output | 1 | Gated receive DMA request |

## Verification
The level logic is swept over every level code, including one reserved code. For each code the fill count is set one entry short of the threshold and then exactly at it, so an off-by-one or a wrong fraction shows up at once. Single-slot mode is driven with fills of 0 and 1, which FIFO mode would treat differently. This separates the two condition sets. The timeout is checked one tick short of the limit and at the limit, with a push in mid-count, and with its mask cleared. Error pulses are sent alone and together with a clear, and zero clear words are written, which separates set priority from plain clearing.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int STAT_W = 11;

    localparam int B_OVR  = 10;
    localparam int B_BRK  = 9;
    localparam int B_PAR  = 8;
    localparam int B_FRM  = 7;
    localparam int B_TMO  = 6;
    localparam int B_TXL  = 5;
    localparam int B_RXL  = 4;
    localparam int B_CTS  = 1;

    localparam logic [STAT_W-1:0] IMPL_BITS = 11'b111_1111_0010;
    localparam logic [STAT_W-1:0] ERR_BITS  = 11'b111_1000_0000;

    typedef enum logic [2:0] {
        LVL_EIGHTH   = 3'd0,
        LVL_QUARTER  = 3'd1,
        LVL_HALF     = 3'd2,
        LVL_3QUARTER = 3'd3,
        LVL_7EIGHTHS = 3'd4
    } lvl_code_e;

    typedef struct packed {
        logic rx_lvl;
        logic tx_lvl;
        logic tmo;
    } level_cond_t;

    function automatic int unsigned lvl_thr(input logic [2:0] code, input int unsigned depth);
        int unsigned eighths;
        case (code)
            LVL_EIGHTH:   eighths = 1;
            LVL_QUARTER:  eighths = 2;
            LVL_HALF:     eighths = 4;
            LVL_3QUARTER: eighths = 6;
            default:      eighths = 7;
        endcase
        return (depth * eighths) / 8;
    endfunction

endpackage

// File: rtl/irq_level_detect.sv
module irq_level_detect #(
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned FILL_W = 6,
    parameter bit          IS_RX  = 1'b1
) (
    input  logic              fifo_en,
    input  logic [2:0]        lvl_code,
    input  logic [FILL_W-1:0] fill,
    output logic              cond
);
    import uart_irq_pkg::*;

    logic [FILL_W-1:0] thr;

    always_comb thr = FILL_W'(lvl_thr(lvl_code, DEPTH));

    generate
        if (IS_RX) begin : g_rx
            always_comb cond = fifo_en ? (fill >= thr) : (fill != '0);
        end else begin : g_tx
            always_comb cond = fifo_en ? (fill <= thr) : (fill == '0);
        end
    endgenerate

endmodule

// File: rtl/irq_rx_timeout.sv
module irq_rx_timeout #(
    parameter int unsigned TO_BITS = 32,
    localparam int unsigned CNT_W  = $clog2(TO_BITS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic nonempty,
    input  logic push,
    input  logic tick,
    output logic fire
);
    logic [CNT_W-1:0] cnt;
    logic             at_end;

    always_comb at_end = (cnt == CNT_W'(TO_BITS - 1));
    always_comb fire   = enable && nonempty && !push && tick && at_end;

    always_ff @(posedge clk) begin
        if (rst || !enable || !nonempty || push) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= at_end ? '0 : cnt + 1'b1;
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
    parameter int unsigned STAT_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [STAT_W-1:0] set_vec,
    input  logic [STAT_W-1:0] drop_vec,
    input  logic              clr_wr,
    input  logic [STAT_W-1:0] clr_wdata,
    input  logic              mask_wr,
    input  logic [STAT_W-1:0] mask_wdata,
    output logic [STAT_W-1:0] raw_q,
    output logic [STAT_W-1:0] mask_out,
    output logic [STAT_W-1:0] masked,
    output logic              any_irq
);
    import uart_irq_pkg::*;

    logic [STAT_W-1:0] clr_m;
    logic [STAT_W-1:0] raw_n;

    always_comb begin
        clr_m  = clr_wr ? clr_wdata : '0;
        raw_n  = ((raw_q & ~clr_m & ~drop_vec) | set_vec) & IMPL_BITS;
        masked = raw_q & mask_out;
        any_irq = |masked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q    <= '0;
            mask_out <= '0;
        end else begin
            raw_q <= raw_n;
            if (mask_wr) mask_out <= mask_wdata & IMPL_BITS;
        end
    end

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl #(
    parameter int unsigned DEPTH   = 32,
    parameter int unsigned TO_BITS = 32,
    localparam int unsigned FILL_W = $clog2(DEPTH + 1),
    localparam int unsigned SW     = uart_irq_pkg::STAT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_fifo_en,
    input  logic [2:0]        cfg_rx_lvl,
    input  logic [2:0]        cfg_tx_lvl,
    input  logic              cfg_dma_err_block,
    input  logic [FILL_W-1:0] rx_fill,
    input  logic [FILL_W-1:0] tx_fill,
    input  logic              rx_push,
    input  logic              bit_tick,
    input  logic              ev_overrun,
    input  logic              ev_break,
    input  logic              ev_parity,
    input  logic              ev_framing,
    input  logic              ev_cts,
    input  logic              mask_wr,
    input  logic [SW-1:0]     mask_wdata,
    input  logic              clr_wr,
    input  logic [SW-1:0]     clr_wdata,
    input  logic              rx_dma_req_in,
    output logic [SW-1:0]     raw_stat,
    output logic [SW-1:0]     mask_q,
    output logic [SW-1:0]     masked_stat,
    output logic              irq,
    output logic              rx_dma_req
);
    import uart_irq_pkg::*;

    level_cond_t now_c, prev_c;
    logic        tmo_fire;
    logic [SW-1:0] set_vec, drop_vec;

    irq_level_detect #(.DEPTH(DEPTH), .FILL_W(FILL_W), .IS_RX(1'b1)) u_rx_lvl (
        .fifo_en(cfg_fifo_en), .lvl_code(cfg_rx_lvl), .fill(rx_fill), .cond(now_c.rx_lvl)
    );

    irq_level_detect #(.DEPTH(DEPTH), .FILL_W(FILL_W), .IS_RX(1'b0)) u_tx_lvl (
        .fifo_en(cfg_fifo_en), .lvl_code(cfg_tx_lvl), .fill(tx_fill), .cond(now_c.tx_lvl)
    );

    always_comb now_c.tmo = (rx_fill != '0);

    irq_rx_timeout #(.TO_BITS(TO_BITS)) u_tmo (
        .clk(clk), .rst(rst), .enable(mask_q[B_TMO]), .nonempty(now_c.tmo),
        .push(rx_push), .tick(bit_tick), .fire(tmo_fire)
    );

    always_ff @(posedge clk) begin
        if (rst) prev_c <= '0;
        else     prev_c <= now_c;
    end

    always_comb begin
        set_vec        = '0;
        set_vec[B_OVR] = ev_overrun;
        set_vec[B_BRK] = ev_break;
        set_vec[B_PAR] = ev_parity;
        set_vec[B_FRM] = ev_framing;
        set_vec[B_CTS] = ev_cts;
        set_vec[B_TMO] = tmo_fire;
        set_vec[B_RXL] = now_c.rx_lvl && !prev_c.rx_lvl;
        set_vec[B_TXL] = now_c.tx_lvl && !prev_c.tx_lvl;

        drop_vec        = '0;
        drop_vec[B_RXL] = !now_c.rx_lvl;
        drop_vec[B_TXL] = !now_c.tx_lvl;
        drop_vec[B_TMO] = !now_c.tmo;
    end

    irq_status_bank #(.STAT_W(SW)) u_bank (
        .clk(clk), .rst(rst), .set_vec(set_vec), .drop_vec(drop_vec),
        .clr_wr(clr_wr), .clr_wdata(clr_wdata), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
        .raw_q(raw_stat), .mask_out(mask_q), .masked(masked_stat), .any_irq(irq)
    );

    always_comb rx_dma_req = rx_dma_req_in && !(cfg_dma_err_block && |(raw_stat & ERR_BITS));

endmodule

// File: rtl/uart_irq_chk.sv
module uart_irq_chk (
    input logic        clk,
    input logic        rst,
    input logic        ev_overrun,
    input logic        clr_wr,
    input logic [10:0] clr_wdata,
    input logic [5:0]  rx_fill,
    input logic        cfg_dma_err_block,
    input logic [10:0] raw_stat,
    input logic [10:0] mask_q,
    input logic        irq,
    input logic        rx_dma_req
);
    AST_TMO_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rx_fill == '0) |=> !raw_stat[6]);                                     // R4
    AST_TMO_NEEDS_MASK: assert property (@(posedge clk) disable iff (rst)
        $rose(raw_stat[6]) |-> $past(mask_q[6]));                              // R5
    AST_OVR_SETS: assert property (@(posedge clk) disable iff (rst)
        ev_overrun |=> raw_stat[10]);                                          // R6
    AST_CLR_OVR: assert property (@(posedge clk) disable iff (rst)
        (clr_wr && clr_wdata[10] && !ev_overrun) |=> !raw_stat[10]);           // R7
    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq);                                              // R9
    AST_DMA_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        (cfg_dma_err_block && (|raw_stat[10:7])) |-> !rx_dma_req);             // R10
endmodule

bind uart_irq_ctrl uart_irq_chk u_irq_chk (
    .clk(clk), .rst(rst), .ev_overrun(ev_overrun), .clr_wr(clr_wr), .clr_wdata(clr_wdata),
    .rx_fill(rx_fill), .cfg_dma_err_block(cfg_dma_err_block), .raw_stat(raw_stat),
    .mask_q(mask_q), .irq(irq), .rx_dma_req(rx_dma_req)
);

// File: tb/test_uart_irq_ctrl.sv
`timescale 1ns/1ps
module test_uart_irq_ctrl;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_fifo_en = 1'b1;
    logic [2:0] cfg_rx_lvl = '0, cfg_tx_lvl = '0;
    logic cfg_dma_err_block = 1'b0;
    logic [5:0] rx_fill = '0, tx_fill = '0;
    logic rx_push = 0, bit_tick = 0;
    logic ev_overrun = 0, ev_break = 0, ev_parity = 0, ev_framing = 0, ev_cts = 0;
    logic mask_wr = 0, clr_wr = 0;
    logic [10:0] mask_wdata = '0, clr_wdata = '0;
    logic rx_dma_req_in = 0;
    logic [10:0] raw_stat, mask_q, masked_stat;
    logic irq, rx_dma_req;

    int n_chk = 0, n_bad = 0;

    always #2.5 clk = ~clk;

    uart_irq_ctrl i_uart_irq_ctrl (.*);

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic chk(input string req, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    function automatic int thr_of(input int code);
        case (code)
            0: return 4; 1: return 8; 2: return 16; 3: return 24;
            default: return 28;
        endcase
    endfunction

    task automatic clr_bits(input logic [10:0] v);
        clr_wr = 1; clr_wdata = v; step(); clr_wr = 0; clr_wdata = '0;
    endtask

    task automatic t_reset();
        rst = 1; step(); step();
        chk("R11 raw", raw_stat, 0);
        chk("R11 mask", mask_q, 0);
        chk("R11 irq", irq, 0);
        rst = 0; step();
        chk("R2 tx empty after reset", raw_stat[5], 1);
    endtask

    task automatic t_levels();
        cfg_fifo_en = 1;
        foreach (thr_of_codes[i]) begin
            int c = thr_of_codes[i];
            int t = thr_of(c);
            cfg_rx_lvl = 3'(c); cfg_tx_lvl = 3'(c);
            rx_fill = 0; tx_fill = 32; step();
            rx_fill = 6'(t - 1); tx_fill = 6'(t + 1); step();
            chk($sformatf("R1 rx below code %0d", c), raw_stat[4], 0);
            chk($sformatf("R1 tx above code %0d", c), raw_stat[5], 0);
            rx_fill = 6'(t); tx_fill = 6'(t); step();
            chk($sformatf("R1 R2 rx at code %0d", c), raw_stat[4], 1);
            chk($sformatf("R1 R2 tx at code %0d", c), raw_stat[5], 1);
        end
        clr_bits(11'h000);
        chk("R7 zero clear keeps", raw_stat[4], 1);
        clr_bits(11'h010);
        chk("R7 clear rx level", raw_stat[4], 0);
        step();
        chk("R2 no re-set while held", raw_stat[4], 0);
        rx_fill = 0; step();
    endtask

    int thr_of_codes[6] = '{0, 1, 2, 3, 4, 7};

    task automatic t_single_slot();
        cfg_fifo_en = 0; cfg_rx_lvl = 0;
        rx_fill = 0; tx_fill = 1; step();
        chk("R3 tx occupied", raw_stat[5], 0);
        rx_fill = 1; step();
        chk("R3 rx one char", raw_stat[4], 1);
        tx_fill = 0; step();
        chk("R3 tx empty", raw_stat[5], 1);
        rx_fill = 0; cfg_fifo_en = 1; step();
    endtask

    task automatic t_errors();
        ev_parity = 1; step(); ev_parity = 0; step();
        chk("R6 parity held", raw_stat[8], 1);
        ev_parity = 1; clr_wr = 1; clr_wdata = 11'h100; step();
        ev_parity = 0; clr_wr = 0; clr_wdata = '0;
        chk("R6 set beats clear", raw_stat[8], 1);
        ev_cts = 1; ev_break = 1; step(); ev_cts = 0; ev_break = 0;
        chk("R6 cts and break", int'({raw_stat[9], raw_stat[1]}), 3);
        clr_bits(11'h302);
        chk("R7 clear parity break cts", int'({raw_stat[9], raw_stat[8], raw_stat[1]}), 0);
    endtask

    task automatic t_mask();
        mask_wr = 1; mask_wdata = 11'h7FF; step(); mask_wr = 0;
        chk("R8 mask impl bits", mask_q, 11'h7F2);
        chk("R8 masked and", masked_stat, raw_stat & mask_q);
        chk("R9 irq or", irq, int'(|(raw_stat & mask_q)));
        mask_wr = 1; mask_wdata = 11'h100; step(); mask_wr = 0;
        ev_parity = 1; step(); ev_parity = 0;
        chk("R9 irq on parity", irq, 1);
        clr_bits(11'h100);
        chk("R9 irq masked off", irq, 0);
        chk("R8 masked zero", masked_stat, 0);
    endtask

    task automatic t_timeout();
        mask_wr = 1; mask_wdata = 11'h000; step(); mask_wr = 0;
        rx_fill = 1; bit_tick = 1;
        repeat (40) step();
        chk("R5 gated by mask", raw_stat[6], 0);
        bit_tick = 0;
        mask_wr = 1; mask_wdata = 11'h040; step(); mask_wr = 0;
        rx_push = 1; step(); rx_push = 0;
        bit_tick = 1; repeat (20) step();
        bit_tick = 0; rx_push = 1; step(); rx_push = 0;
        bit_tick = 1; repeat (31) step();
        chk("R4 31 ticks after push", raw_stat[6], 0);
        step();
        chk("R4 32 ticks", raw_stat[6], 1);
        bit_tick = 0;
        clr_bits(11'h040);
        chk("R4 clear bit", raw_stat[6], 0);
        bit_tick = 1; repeat (32) step(); bit_tick = 0;
        chk("R4 fires again", raw_stat[6], 1);
        rx_fill = 0; step();
        chk("R4 drained", raw_stat[6], 0);
    endtask

    task automatic t_dma();
        rx_dma_req_in = 1; cfg_dma_err_block = 1; step();
        chk("R10 no errors passes", rx_dma_req, 1);
        ev_overrun = 1; step(); ev_overrun = 0;
        chk("R10 blocked", rx_dma_req, 0);
        cfg_dma_err_block = 0; #1;
        chk("R10 block off", rx_dma_req, 1);
        clr_bits(11'h400); cfg_dma_err_block = 1; #1;
        chk("R10 cleared passes", rx_dma_req, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_levels();
        t_single_slot();
        t_errors();
        t_mask();
        t_timeout();
        t_dma();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule